// File: doc/BRIEF.md
# Transition-Signaled Circular FIFO Buffer

A circular buffer of eight 16-bit words for the input side of a network-on-chip router. Words enter and leave through two-phase handshakes. A producer offers a word by toggling `in_req`, and the buffer takes it by toggling `in_ack` to match. The buffer offers a word by toggling `out_req`, and the consumer takes it by toggling `out_ack` to match. Each handshake is one toggle in each direction.

There is no binary pointer and no occupancy counter. Each slot keeps a pair of phase bits: one toggled by its write side and one toggled by its read side. The slot holds a word exactly when the two bits differ. One-hot write and read selects rotate one position per completed transfer. While a slot is empty and selected for writing, its storage follows the input data, like an open latch. The storage closes on the write, and the full phase toggles at that same moment. An AND-OR multiplexer keyed by the read select drives the output data.

This is a clocked model. All handshake inputs are sampled on the rising edge of `clk`, and the reset is synchronous.

Top module: `ts_fifo`

## Requirements
- R1: Words leave in the order they were accepted. This holds across any number of wraparounds of the 8 slots, and each word keeps its 16-bit value.
- R2: While `rst` is high at a clock edge, `in_ack` and `out_req` go to 0 and the buffer becomes empty. After reset, no word is offered until one is written.
- R3: A write is pending while `in_req` differs from `in_ack`. If the selected slot is empty, the word on `in_data` is stored at the next rising edge, and `in_ack` toggles at that same edge. `in_ack` toggles exactly once per stored word.
- R4: While the slot selected for writing still holds a word (the buffer holds 8 words), a pending write is not taken and `in_ack` does not toggle.
- R5: When no offer is outstanding and the slot selected for reading holds a word, `out_req` toggles at the next rising edge. `out_data` shows that word while `out_req` differs from `out_ack`.
- R6: When `out_ack` is toggled to equal `out_req`, the offered word is consumed at the next rising edge. That slot becomes empty, and the read select moves to the next slot.
- R7: `out_req` never toggles while the slot selected for reading is empty.
- R8: `out_data` stays unchanged while an offer is outstanding.
- R9: A write blocked under R4 is taken once a read frees the slot that the write select points at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Producer request toggle |
| in_data | input | 16 | Word offered by the producer |
| in_ack | output | 1 | Acknowledge toggle to the producer |
| out_req | output | 1 | Request toggle to the consumer |
| out_data | output | 16 | Word offered to the consumer |
| out_ack | input | 1 | Consumer acknowledge toggle |

## Verification
The assertions are checked on every cycle. They check that both selects stay one-hot, and that an input acknowledge comes only for a pending write into an empty slot, with the write select rotating at that edge. They also check that a slot's full phase turns only when the stored word equals the data sampled, that no offer is raised from an empty slot, and that offered data holds steady. Some properties need a history of transfers, and only the bench scenarios show them. These are first-in first-out order across wraparound, a ninth write stalling until a read frees its slot, and the buffer coming back empty after a reset in mid-traffic.

// File: rtl/ts_fifo.sv
module ts_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_req,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ack,
  output logic             out_req,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ack
);
  logic [DEPTH-1:0] wr_sel, rd_sel, full_ph, empty_ph, holding;
  logic [DEPTH-1:0][WIDTH-1:0] slot_q;
  logic in_ack_q, out_req_q, offered;
  logic wr_fire, rd_full, rd_done, rd_offer;

  assign holding  = full_ph ^ empty_ph;
  assign wr_fire  = (in_req ^ in_ack_q) & ~|(wr_sel & holding);
  assign rd_full  = |(rd_sel & holding);
  assign rd_done  = offered & ~(out_req_q ^ out_ack);
  assign rd_offer = ~offered & rd_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel    <= DEPTH'(1);
      rd_sel    <= DEPTH'(1);
      in_ack_q  <= 1'b0;
      out_req_q <= 1'b0;
      offered   <= 1'b0;
    end else begin
      if (wr_fire) begin
        in_ack_q <= ~in_ack_q;
        wr_sel   <= {wr_sel[DEPTH-2:0], wr_sel[DEPTH-1]};
      end
      if (rd_done) begin
        offered <= 1'b0;
        rd_sel  <= {rd_sel[DEPTH-2:0], rd_sel[DEPTH-1]};
      end else if (rd_offer) begin
        offered   <= 1'b1;
        out_req_q <= ~out_req_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        full_ph[i]  <= 1'b0;
        empty_ph[i] <= 1'b0;
        slot_q[i]   <= '0;
      end else begin
        if (wr_sel[i] && !holding[i]) slot_q[i] <= in_data;
        if (wr_fire && wr_sel[i]) full_ph[i] <= ~full_ph[i];
        if (rd_done && rd_sel[i]) empty_ph[i] <= ~empty_ph[i];
      end
    end
  end

  always_comb begin
    out_data = '0;
    for (int i = 0; i < DEPTH; i++)
      out_data = out_data | (slot_q[i] & {WIDTH{rd_sel[i]}});
  end

  assign in_ack  = in_ack_q;
  assign out_req = out_req_q;
endmodule

// File: rtl/ts_fifo_chk.sv
module ts_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_req,
  input logic [WIDTH-1:0]            in_data,
  input logic                        in_ack,
  input logic                        out_req,
  input logic [WIDTH-1:0]            out_data,
  input logic                        out_ack,
  input logic [DEPTH-1:0]            wr_sel,
  input logic [DEPTH-1:0]            rd_sel,
  input logic [DEPTH-1:0]            holding,
  input logic [DEPTH-1:0]            full_ph,
  input logic [DEPTH-1:0][WIDTH-1:0] slot_q
);
  p_onehot_sel_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot(wr_sel) && $onehot(rd_sel));

  p_ack_needs_room_r4: assert property (@(posedge clk) disable iff (rst)
    (in_ack != $past(in_ack)) |-> ($past(in_req != in_ack) && !$past(|(wr_sel & holding))));

  p_ack_rotates_r3: assert property (@(posedge clk) disable iff (rst)
    (in_ack != $past(in_ack)) |-> (wr_sel == $past({wr_sel[DEPTH-2:0], wr_sel[DEPTH-1]})));

  p_no_offer_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (out_req != $past(out_req)) |-> $past(|(rd_sel & holding)));

  p_data_steady_r8: assert property (@(posedge clk) disable iff (rst)
    ((out_req != out_ack) && $past(out_req != out_ack) && $stable(out_req)) |-> $stable(out_data));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    p_held_before_full_r3: assert property (@(posedge clk) disable iff (rst)
      (full_ph[i] != $past(full_ph[i])) |-> (slot_q[i] == $past(in_data)));
  end
endmodule

bind ts_fifo ts_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
  .out_req(out_req), .out_data(out_data), .out_ack(out_ack),
  .wr_sel(wr_sel), .rd_sel(rd_sel), .holding(holding), .full_ph(full_ph),
  .slot_q(slot_q)
);

// File: tb/test_ts_fifo.sv
module test_ts_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_req = 1'b0;
  logic out_ack = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ack, out_req;
  logic [15:0] out_data;
  integer checks = 0, errors = 0;
  logic [15:0] q[$];

  always #10 clk = ~clk;

  ts_fifo i_ts_fifo (.clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack));

  // bit 16: 1 = write of bits 15:0, 0 = read
  localparam int NV = 26;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {1'b1,16'h1A01},{1'b1,16'h2B02},{1'b1,16'h3C03},{1'b1,16'h4D04},
    {1'b1,16'h5E05},{1'b1,16'h6F06},{1'b0,16'h0},{1'b0,16'h0},{1'b0,16'h0},
    {1'b1,16'h7007},{1'b1,16'h8118},{1'b1,16'h9229},{1'b1,16'hA33A},
    {1'b1,16'hFFFF},{1'b0,16'h0},{1'b0,16'h0},{1'b0,16'h0},{1'b0,16'h0},
    {1'b0,16'h0},{1'b0,16'h0},{1'b0,16'h0},{1'b0,16'h0},
    {1'b1,16'h0000},{1'b1,16'hC55C},{1'b0,16'h0},{1'b0,16'h0}};

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] d);
    bit got = 0;
    @(negedge clk);
    in_data = d;
    in_req = ~in_req;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (in_ack == in_req) begin got = 1; break; end
    end
    check(got, "R3 write acknowledged", {15'd0, in_ack}, {15'd0, in_req});
    if (got) q.push_back(d);
  endtask

  task automatic do_read();
    bit seen = 0;
    logic [15:0] got;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_req != out_ack) begin seen = 1; break; end
    end
    check(seen == (q.size() != 0), "R5 offer present", {15'd0, seen}, {15'd0, q.size() != 0});
    if (seen && q.size() != 0) begin
      got = out_data;
      check(got == q[0], "R1 order and value", got, q[0]);
      @(negedge clk);
      check(out_data == got, "R8 data held during offer", out_data, got);
      out_ack = out_req;
      void'(q.pop_front());
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit stalled;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(in_ack == 0 && out_req == 0, "R2 reset outputs", {14'd0, in_ack, out_req}, 16'd0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][16]) do_write(VEC[v][15:0]);
      else do_read();
    end

    // fill all slots, then a ninth write must stall
    for (int k = 0; k < 8; k++) do_write(16'hB000 + 16'(k));
    @(negedge clk);
    in_data = 16'hDEAD;
    in_req = ~in_req;
    stalled = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (in_ack == in_req) stalled = 0;
    end
    check(stalled, "R4 write blocked when full", {15'd0, in_ack}, {15'd0, ~in_req});
    do_read();
    stalled = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (in_ack == in_req) begin stalled = 0; break; end
    end
    check(!stalled, "R9 blocked write taken after read", {15'd0, in_ack}, {15'd0, in_req});
    if (!stalled) q.push_back(16'hDEAD);
    while (q.size() != 0) do_read();

    // empty: no offer may appear
    stalled = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_req != out_ack) stalled = 0;
    end
    check(stalled, "R7 no offer when empty", {15'd0, out_req}, {15'd0, out_ack});

    // R6: consume completes only on ack; without ack the offer stays
    do_write(16'h5A5A);
    repeat (4) @(negedge clk);
    check(out_req != out_ack, "R6 offer waits for ack", {15'd0, out_req}, {15'd0, ~out_ack});
    do_read();
    repeat (4) @(negedge clk);
    check(out_req == out_ack, "R6 slot freed after ack", {15'd0, out_req}, {15'd0, out_ack});

    // reset in mid-traffic
    do_write(16'h1111);
    do_write(16'h2222);
    @(negedge clk);
    rst = 1'b1;
    in_req = 1'b0;
    out_ack = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(in_ack == 0 && out_req == 0, "R2 reset mid-run outputs", {14'd0, in_ack, out_req}, 16'd0);
    do_read();
    do_write(16'h7777);
    do_read();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule